// File: doc/BRIEF.md
# Address-Range Clean/Invalidate Sequencer

This block carries out one cache maintenance command over a span of bytes. A command gives a byte address, a byte length and two independent flags: clean and invalidate. The span is widened outward to whole cache lines at both ends. The sequencer then visits each line of the widened span in ascending order. For each line it issues a lookup to the tag store through a request/response port and receives a hit flag, a dirty flag and a way index. On a hit it sends one update back to the tag store. The update can clear the dirty flag if clean was requested and the line was dirty. It can also clear the valid flag if invalidate was requested. Each dirty line that is cleaned counts as one writeback.

When the local walk is over, the block hands the same command to the next cache level. It passes on the unaligned address, the length and both flags exactly as received, and holds them until the next level acknowledges. One command is in flight at a time. The block reports busy from acceptance until that acknowledgement, and refuses new commands for the whole period. The tag storage and the movement of writeback data belong to the surrounding logic.

Top module: `range_maint_seq`

## Requirements
- R1: The first lookup address is the command address rounded down to a multiple of LINE_BYTES.
- R2: The exclusive end bound is (address + length + LINE_BYTES - 1) rounded down to a multiple of LINE_BYTES, computed without wraparound. Lookups are issued exactly for line addresses below this bound, so a walk makes (bound - first) / LINE_BYTES lookups.
- R3: Each lookup address after the first is exactly LINE_BYTES above the previous one in the same command.
- R4: A line whose lookup returns a miss (lk_hit_i = 0) gets no update, and the writeback count stays the same.
- R5: With clean set, a hit on a dirty line (lk_dirty_i = 1) produces an update with upd_clr_dirty_o = 1, and wb_count_o rises by one. A hit on a line that is not dirty leaves the dirty flag untouched and the count unchanged. The count wraps modulo 2^CNT_W.
- R6: With invalidate set, every hit produces an update with upd_clr_valid_o = 1. When both flags apply to the same line, a single update clears both flags. With neither flag set, no update is issued.
- R7: After the last line, fwd_valid_o rises and presents the command's original address, length, clean and invalidate values. It holds them unchanged until fwd_ready_i is seen high on a clock edge.
- R8: A zero length with an aligned address issues no lookup but still forwards the command. A zero length with an unaligned address visits exactly one line.
- R9: busy_o is high and cmd_ready_o is low from the cycle after acceptance until the cycle after the forward handshake. A command offered during that time is not taken and causes no lookup.
- R10: lk_hit_i, lk_dirty_i and lk_way_i are sampled one cycle after lk_req_o. The update for that line is presented on the following cycle, carrying the same line address and the returned way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_addr_i | input | ADDR_W | Command byte address, may be unaligned |
| cmd_len_i | input | LEN_W | Command byte length |
| cmd_clean_i | input | 1 | Request clean of dirty lines |
| cmd_inval_i | input | 1 | Request invalidation of lines |
| cmd_ready_o | output | 1 | Command accepted when high with cmd_valid_i |
| busy_o | output | 1 | A command is in progress |
| lk_req_o | output | 1 | Tag lookup request, one cycle |
| lk_addr_o | output | ADDR_W | Line-aligned lookup address |
| lk_hit_i | input | 1 | Lookup hit, one cycle after request |
| lk_dirty_i | input | 1 | Hit line is dirty, one cycle after request |
| lk_way_i | input | WAY_W | Way of the hit line, one cycle after request |
| upd_valid_o | output | 1 | Flag update for the looked-up line |
| upd_addr_o | output | ADDR_W | Line address of the update |
| upd_way_o | output | WAY_W | Way to update |
| upd_clr_dirty_o | output | 1 | Clear the dirty flag |
| upd_clr_valid_o | output | 1 | Clear the valid flag |
| fwd_valid_o | output | 1 | Command forwarded to next level |
| fwd_addr_o | output | ADDR_W | Forwarded original address |
| fwd_len_o | output | LEN_W | Forwarded original length |
| fwd_clean_o | output | 1 | Forwarded clean flag |
| fwd_inval_o | output | 1 | Forwarded invalidate flag |
| fwd_ready_i | input | 1 | Next level takes the forwarded command |
| wb_count_o | output | CNT_W | Number of writebacks, wrapping |

## Verification
The bench uses the defaults: 16-bit addresses, 12-bit lengths, 16-byte lines, a 2-bit way index and an 8-bit writeback count. It keeps a model tag store of 64 lines over the low kilobyte of the address space. With 16-byte lines, short unaligned spans such as 0x23 + 0x30 already cover several lines and have partial lines at both ends. This also makes both zero-length corner cases cheap to build. The forward stage is stalled for several cycles while a second command is offered, which exercises the hold and busy rules.

// File: rtl/rms_pkg.sv
package rms_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RESP,
    ST_UPD,
    ST_FWD
  } rms_state_e;
endpackage

// File: rtl/rms_range.sv
module rms_range #(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W:0]   first_o,
  output logic [ADDR_W:0]   bound_o
);
  localparam logic [ADDR_W:0] LINE_MASK = (ADDR_W+1)'(LINE_BYTES - 1);

  logic [ADDR_W:0] span_end;

  // one extra bit keeps the rounded-up bound from wrapping
  assign span_end = {1'b0, addr_i} + (ADDR_W+1)'(len_i) + LINE_MASK;
  assign first_o  = {1'b0, addr_i} & ~LINE_MASK;
  assign bound_o  = span_end & ~LINE_MASK;
endmodule

// File: rtl/rms_wb_cnt.sv
module rms_wb_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  a_r5_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));
  a_r5_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/rms_ctrl.sv
module rms_ctrl
  import rms_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16,
  parameter int WAY_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic              cmd_clean_i,
  input  logic              cmd_inval_i,
  input  logic [ADDR_W:0]   first_i,
  input  logic [ADDR_W:0]   bound_i,
  output logic              cmd_ready_o,
  output logic              busy_o,
  output logic              lk_req_o,
  output logic [ADDR_W-1:0] lk_addr_o,
  input  logic              lk_hit_i,
  input  logic              lk_dirty_i,
  input  logic [WAY_W-1:0]  lk_way_i,
  output logic              upd_valid_o,
  output logic [ADDR_W-1:0] upd_addr_o,
  output logic [WAY_W-1:0]  upd_way_o,
  output logic              upd_clr_dirty_o,
  output logic              upd_clr_valid_o,
  output logic              fwd_valid_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  output logic [LEN_W-1:0]  fwd_len_o,
  output logic              fwd_clean_o,
  output logic              fwd_inval_o,
  input  logic              fwd_ready_i
);
  localparam logic [ADDR_W:0] LINE_STEP = (ADDR_W+1)'(LINE_BYTES);

  rms_state_e        state_q;
  logic [ADDR_W:0]   cur_q, bound_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              clean_q, inval_q;
  logic              hit_q, dirty_q;
  logic [WAY_W-1:0]  way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      bound_q <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      clean_q <= 1'b0;
      inval_q <= 1'b0;
      hit_q   <= 1'b0;
      dirty_q <= 1'b0;
      way_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          addr_q  <= cmd_addr_i;
          len_q   <= cmd_len_i;
          clean_q <= cmd_clean_i;
          inval_q <= cmd_inval_i;
          cur_q   <= first_i;
          bound_q <= bound_i;
          state_q <= ST_LOOK;
        end
        ST_LOOK: state_q <= (cur_q < bound_q) ? ST_RESP : ST_FWD;
        ST_RESP: begin
          hit_q   <= lk_hit_i;
          dirty_q <= lk_dirty_i;
          way_q   <= lk_way_i;
          state_q <= ST_UPD;
        end
        ST_UPD: begin
          cur_q   <= cur_q + LINE_STEP;
          state_q <= ST_LOOK;
        end
        ST_FWD: if (fwd_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic in_upd;
  assign in_upd = (state_q == ST_UPD) && hit_q;

  assign cmd_ready_o     = (state_q == ST_IDLE);
  assign busy_o          = (state_q != ST_IDLE);
  assign lk_req_o        = (state_q == ST_LOOK) && (cur_q < bound_q);
  assign lk_addr_o       = cur_q[ADDR_W-1:0];
  assign upd_clr_dirty_o = in_upd && clean_q && dirty_q;
  assign upd_clr_valid_o = in_upd && inval_q;
  assign upd_valid_o     = upd_clr_dirty_o || upd_clr_valid_o;
  assign upd_addr_o      = cur_q[ADDR_W-1:0];
  assign upd_way_o       = way_q;
  assign fwd_valid_o     = (state_q == ST_FWD);
  assign fwd_addr_o      = addr_q;
  assign fwd_len_o       = len_q;
  assign fwd_clean_o     = clean_q;
  assign fwd_inval_o     = inval_q;

  // last lookup address of the running command, for the stride check
  logic [ADDR_W-1:0] prev_lk_q;
  logic              prev_vld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_lk_q  <= '0;
      prev_vld_q <= 1'b0;
    end else if (cmd_valid_i && cmd_ready_o) begin
      prev_vld_q <= 1'b0;
    end else if (lk_req_o) begin
      prev_lk_q  <= lk_addr_o;
      prev_vld_q <= 1'b1;
    end
  end

  a_r3_line_stride: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_o && prev_vld_q |-> lk_addr_o == prev_lk_q + ADDR_W'(LINE_BYTES));
  a_r10_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_o |=> !lk_req_o);
  a_r10_upd_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> $past(lk_req_o, 2) && upd_addr_o == $past(lk_addr_o, 2));
  a_r4_upd_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> $past(lk_hit_i));
  a_r7_fwd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o && !fwd_ready_i |=> fwd_valid_o && $stable(fwd_addr_o)
      && $stable(fwd_len_o) && $stable(fwd_clean_o) && $stable(fwd_inval_o));
  a_r9_no_walk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !lk_req_o && !upd_valid_o && !fwd_valid_o);
endmodule

// File: rtl/range_maint_seq.sv
module range_maint_seq #(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16,
  parameter int WAY_W      = 2,
  parameter int CNT_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic              cmd_clean_i,
  input  logic              cmd_inval_i,
  output logic              cmd_ready_o,
  output logic              busy_o,
  output logic              lk_req_o,
  output logic [ADDR_W-1:0] lk_addr_o,
  input  logic              lk_hit_i,
  input  logic              lk_dirty_i,
  input  logic [WAY_W-1:0]  lk_way_i,
  output logic              upd_valid_o,
  output logic [ADDR_W-1:0] upd_addr_o,
  output logic [WAY_W-1:0]  upd_way_o,
  output logic              upd_clr_dirty_o,
  output logic              upd_clr_valid_o,
  output logic              fwd_valid_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  output logic [LEN_W-1:0]  fwd_len_o,
  output logic              fwd_clean_o,
  output logic              fwd_inval_o,
  input  logic              fwd_ready_i,
  output logic [CNT_W-1:0]  wb_count_o
);
  logic [ADDR_W:0] first_w, bound_w;

  rms_range #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_range (
    .addr_i (cmd_addr_i),
    .len_i  (cmd_len_i),
    .first_o(first_w),
    .bound_o(bound_w)
  );

  rms_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES), .WAY_W(WAY_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_addr_i     (cmd_addr_i),
    .cmd_len_i      (cmd_len_i),
    .cmd_clean_i    (cmd_clean_i),
    .cmd_inval_i    (cmd_inval_i),
    .first_i        (first_w),
    .bound_i        (bound_w),
    .cmd_ready_o    (cmd_ready_o),
    .busy_o         (busy_o),
    .lk_req_o       (lk_req_o),
    .lk_addr_o      (lk_addr_o),
    .lk_hit_i       (lk_hit_i),
    .lk_dirty_i     (lk_dirty_i),
    .lk_way_i       (lk_way_i),
    .upd_valid_o    (upd_valid_o),
    .upd_addr_o     (upd_addr_o),
    .upd_way_o      (upd_way_o),
    .upd_clr_dirty_o(upd_clr_dirty_o),
    .upd_clr_valid_o(upd_clr_valid_o),
    .fwd_valid_o    (fwd_valid_o),
    .fwd_addr_o     (fwd_addr_o),
    .fwd_len_o      (fwd_len_o),
    .fwd_clean_o    (fwd_clean_o),
    .fwd_inval_o    (fwd_inval_o),
    .fwd_ready_i    (fwd_ready_i)
  );

  rms_wb_cnt #(.CNT_W(CNT_W)) u_wb_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (upd_clr_dirty_o),
    .cnt_o (wb_count_o)
  );
endmodule

// File: tb/tb_range_maint_seq.sv
`timescale 1ns/1ps
module tb_range_maint_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [11:0] cmd_len = '0;
  logic        cmd_clean = 1'b0, cmd_inval = 1'b0;
  logic        cmd_ready, busy;
  logic        lk_req;
  logic [15:0] lk_addr;
  logic        lk_hit = 1'b0, lk_dirty = 1'b0;
  logic [1:0]  lk_way = '0;
  logic        upd_valid, upd_clr_dirty, upd_clr_valid;
  logic [15:0] upd_addr;
  logic [1:0]  upd_way;
  logic        fwd_valid, fwd_clean, fwd_inval;
  logic [15:0] fwd_addr;
  logic [11:0] fwd_len;
  logic        fwd_ready = 1'b0;
  logic [7:0]  wb_count;

  always #4 clk = ~clk;

  range_maint_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len),
    .cmd_clean_i(cmd_clean), .cmd_inval_i(cmd_inval),
    .cmd_ready_o(cmd_ready), .busy_o(busy),
    .lk_req_o(lk_req), .lk_addr_o(lk_addr),
    .lk_hit_i(lk_hit), .lk_dirty_i(lk_dirty), .lk_way_i(lk_way),
    .upd_valid_o(upd_valid), .upd_addr_o(upd_addr), .upd_way_o(upd_way),
    .upd_clr_dirty_o(upd_clr_dirty), .upd_clr_valid_o(upd_clr_valid),
    .fwd_valid_o(fwd_valid), .fwd_addr_o(fwd_addr), .fwd_len_o(fwd_len),
    .fwd_clean_o(fwd_clean), .fwd_inval_o(fwd_inval), .fwd_ready_i(fwd_ready),
    .wb_count_o(wb_count)
  );

  int checks = 0, failures = 0;
  bit v_m [64];
  bit d_m [64];

  // monitor state
  int n_lk, n_upd, n_fwd, step_err, way_err, first_seen;
  logic [15:0] first_lk, last_lk;
  logic [15:0] f_addr;
  logic [11:0] f_len;
  logic        f_clean, f_inval;

  // tag store model: response one cycle after request
  always @(posedge clk) begin
    if (lk_req) begin
      n_lk++;
      if (first_seen == 0) first_lk = lk_addr;
      else if (lk_addr != last_lk + 16'd16) step_err++;
      first_seen = 1;
      last_lk = lk_addr;
      lk_hit   <= (lk_addr < 16'd1024) && v_m[lk_addr[9:4]];
      lk_dirty <= (lk_addr < 16'd1024) && d_m[lk_addr[9:4]];
      lk_way   <= lk_addr[5:4];
    end
    if (upd_valid) begin
      n_upd++;
      if (upd_way != upd_addr[5:4]) way_err++;
      if (upd_addr < 16'd1024) begin
        if (upd_clr_dirty) d_m[upd_addr[9:4]] = 1'b0;
        if (upd_clr_valid) v_m[upd_addr[9:4]] = 1'b0;
      end
    end
    if (fwd_valid && fwd_ready) begin
      n_fwd++;
      f_addr = fwd_addr; f_len = fwd_len; f_clean = fwd_clean; f_inval = fwd_inval;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic set_line(input int idx, input bit v, input bit d);
    v_m[idx] = v; d_m[idx] = d;
  endtask

  // one command end to end, with model comparison
  task automatic run_op(input logic [15:0] a, input logic [11:0] l, input bit c, input bit iv,
                        input int stall, input bit poke);
    bit ev [64];
    bit ed [64];
    int first, endb, exp_wb, exp_upd, lk_before, tmo, bad;
    logic [7:0] wb0;
    for (int i = 0; i < 64; i++) begin ev[i] = v_m[i]; ed[i] = d_m[i]; end
    first = int'(a) & ~15;
    endb  = (int'(a) + int'(l) + 15) & ~15;
    exp_wb = 0; exp_upd = 0;
    for (int x = first; x < endb; x += 16) begin
      int idx = (x >> 4) & 63;
      if (x < 1024 && ev[idx]) begin
        if ((c && ed[idx]) || iv) exp_upd++;
        if (c && ed[idx]) begin ed[idx] = 1'b0; exp_wb++; end
        if (iv) ev[idx] = 1'b0;
      end
    end
    n_lk = 0; n_upd = 0; n_fwd = 0; step_err = 0; way_err = 0; first_seen = 0;
    wb0 = wb_count;
    @(negedge clk);
    cmd_addr = a; cmd_len = l; cmd_clean = c; cmd_inval = iv; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R9 busy after accept", int'(busy), 1);
    tmo = 0;
    while (!fwd_valid && tmo < 5000) begin @(negedge clk); tmo++; end
    chk(fwd_valid, "R7 forward raised", int'(fwd_valid), 1);
    lk_before = n_lk; bad = 0;
    for (int k = 0; k < stall; k++) begin
      if (poke) begin
        cmd_addr = 16'h0100; cmd_len = 12'h40; cmd_clean = 1'b1; cmd_inval = 1'b1; cmd_valid = 1'b1;
      end
      @(negedge clk);
      if (!fwd_valid || !busy || cmd_ready || fwd_addr != a || fwd_len != l) bad++;
    end
    cmd_valid = 1'b0;
    if (stall > 0) begin
      chk(bad == 0, "R7 forward held during stall", bad, 0);
      chk(n_lk == lk_before, "R9 no lookup while busy", n_lk - lk_before, 0);
    end
    fwd_ready = 1'b1;
    @(negedge clk);
    fwd_ready = 1'b0;
    chk(!busy && cmd_ready, "R9 idle after forward ack", int'(busy), 0);
    chk(n_lk == (endb - first) / 16, "R2 lookup count", n_lk, (endb - first) / 16);
    if (n_lk > 0) chk(first_lk == 16'(first), "R1 first line address", int'(first_lk), first);
    chk(step_err == 0, "R3 line stride", step_err, 0);
    chk(n_upd == exp_upd, "R4 update count", n_upd, exp_upd);
    chk(way_err == 0, "R10 update way matches lookup", way_err, 0);
    chk(8'(wb_count - wb0) == 8'(exp_wb), "R5 writeback delta", int'(8'(wb_count - wb0)), exp_wb);
    bad = 0;
    for (int i = 0; i < 64; i++) if (v_m[i] != ev[i] || d_m[i] != ed[i]) bad++;
    chk(bad == 0, "R6 tag flags after walk", bad, 0);
    chk(n_fwd == 1 && f_addr == a && f_len == l && f_clean == c && f_inval == iv,
        "R7 forwarded fields", int'(f_addr), int'(a));
  endtask

  task automatic t_reset();
    chk(!busy && cmd_ready && !fwd_valid && !lk_req && wb_count == 8'd0,
        "R9 reset state idle", int'(busy), 0);
  endtask

  task automatic t_clean(); // R5: dirty lines cleaned, clean hit untouched
    for (int i = 0; i < 64; i++) set_line(i, 1'b0, 1'b0);
    set_line(2, 1, 1); set_line(3, 1, 0); set_line(4, 1, 1); set_line(5, 1, 1); set_line(6, 1, 1);
    run_op(16'h0023, 12'h030, 1'b1, 1'b0, 0, 1'b0);
    chk(d_m[6] == 1'b1, "R2 line past bound untouched", int'(d_m[6]), 1);
  endtask

  task automatic t_inval(); // R6
    set_line(8, 1, 1); set_line(9, 1, 0); set_line(10, 1, 1);
    run_op(16'h0080, 12'h030, 1'b0, 1'b1, 0, 1'b0);
    chk(d_m[8] == 1'b1 && v_m[8] == 1'b0, "R6 inval keeps dirty", int'(d_m[8]), 1);
  endtask

  task automatic t_both(); // R6 both flags on one line
    set_line(12, 1, 1); set_line(13, 1, 1); set_line(14, 1, 0);
    run_op(16'h00C7, 12'h021, 1'b1, 1'b1, 0, 1'b0);
  endtask

  task automatic t_miss(); // R4
    set_line(16, 0, 1); set_line(17, 0, 1); set_line(18, 1, 1);
    run_op(16'h0100, 12'h020, 1'b1, 1'b1, 0, 1'b0);
    chk(d_m[16] == 1'b1 && d_m[17] == 1'b1, "R4 missed lines unchanged", int'(d_m[16]), 1);
  endtask

  task automatic t_zero(); // R8
    set_line(20, 1, 1); set_line(21, 1, 1);
    run_op(16'h0140, 12'h000, 1'b1, 1'b1, 0, 1'b0);
    chk(v_m[20] == 1'b1, "R8 aligned zero length no change", int'(v_m[20]), 1);
    run_op(16'h0155, 12'h000, 1'b1, 1'b1, 0, 1'b0);
    chk(v_m[21] == 1'b0, "R8 unaligned zero length one line", int'(v_m[21]), 0);
  endtask

  task automatic t_stall(); // R7 R9: stalled forward, second command refused
    set_line(24, 1, 1);
    run_op(16'h018F, 12'h001, 1'b1, 1'b0, 6, 1'b1);
  endtask

  task automatic t_none(); // R6 no flags: no update
    set_line(28, 1, 1); set_line(29, 1, 1);
    run_op(16'h01C0, 12'h020, 1'b0, 1'b0, 2, 1'b0);
  endtask

  task automatic t_wrap(); // R5 counter wraps; R10 timing over a long walk
    for (int i = 0; i < 64; i++) set_line(i, 1, 1);
    for (int r = 0; r < 4; r++) begin
      run_op(16'h0000, 12'h400, 1'b1, 1'b0, 0, 1'b0);
      for (int i = 0; i < 64; i++) set_line(i, 1, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) set_line(i, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_inval();
    t_both();
    t_miss();
    t_zero();
    t_stall();
    t_none();
    t_wrap();
    summary();
    $finish;
  end
endmodule